// File: doc/BRIEF.md
# Privileged State Register Bank

This block keeps the architectural control state of one processor thread: a 16-bit process-state word, a 64-bit hypervisor-state word, the trap level, the global-register level and the current register window. A single write port, addressed by a register select, stores each value after it is filtered. Some process-state bits are dropped. The identity bit of the hypervisor word is always set. The trap and global levels are capped at a limit that depends on the current privilege. The window index saturates.

All stored values appear on dedicated outputs without delay. The block also derives two signals. The first is a user-mode flag. The second is a registered interrupt request that is raised when the hypervisor word asks for a trap-level-zero notice, the trap level is zero and the thread is not hyperprivileged. The request is re-evaluated on every write to the trap level or to the hypervisor word.

Top module: `priv_state_regs`

## Requirements
- R1: After reset the process word reads 0x0014 (bits 2 and 4 set), the hypervisor word reads 0x0000_0000_0000_0824 (bits 2, 5 and 11 set), the trap level and window read 0, the global level reads MAX_GL and the interrupt request is low.
- R2: A write with select 0 stores the low 16 data bits ANDed with 0x0BDE, which keeps bits 1, 2, 3, 4, 6, 7, 8, 9 and 11 and clears bits 0, 5, 10, 12, 13, 14 and 15.
- R3: A write with select 1 stores all 64 data bits with bit 11 forced to 1.
- R4: The interrupt request is 1 exactly when hypervisor bit 0 is 1, the trap level is 0 and hypervisor bit 2 is 0. It is updated at the clock edge that takes a select 1 or select 2 write and is held at all other times.
- R5: A write with select 2 stores the data as the trap level. The value is capped at MAX_PTL when process bit 2 is 1 and hypervisor bit 2 is 0, and at MAX_TL otherwise.
- R6: A write with select 3 stores the data as the global level. The value is capped at MAX_PGL under the same privilege condition as R5, and at MAX_GL otherwise.
- R7: A write with select 4 stores the data as the window index. Values of N_WIN or more become N_WIN-1.
- R8: The user-mode output is 1 exactly when process bit 2 and hypervisor bit 2 are both 0.
- R9: A cycle with the write enable low, or with a select of 5, 6 or 7, changes no stored value and no output.
- R10: The stored values are visible on the outputs in the cycle that follows the write edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 3 | Register select (0 process, 1 hypervisor, 2 trap level, 3 global level, 4 window) |
| wrData | input | 64 | Write data |
| procState | output | 16 | Stored process-state word |
| hypState | output | 64 | Stored hypervisor-state word |
| trapLevel | output | $clog2(MAX_TL+1) | Stored trap level |
| globalLevel | output | $clog2(MAX_GL+1) | Stored global level |
| windowPtr | output | $clog2(N_WIN) | Stored window index |
| userMode | output | 1 | High when neither privilege bit is set |
| tlZeroIrq | output | 1 | Registered trap-level-zero interrupt request |

## Verification
Every stored value, and the interrupt request, changes at the clock edge that takes the write. The bench therefore drives a write on a falling edge and compares all outputs on the next falling edge, which is one edge later, against a model updated once per write. The user-mode flag is combinational on the stored bits and is compared in the same window. Writes with the enable low or with unused selects are compared in the same window, so that a stray update would show up before the next write.

// File: rtl/priv_state_pkg.sv
package priv_state_pkg;

  typedef enum logic [2:0] {
    SEL_PROC = 3'd0,
    SEL_HYP  = 3'd1,
    SEL_TL   = 3'd2,
    SEL_GL   = 3'd3,
    SEL_WIN  = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic wrPs;
    logic wrHp;
    logic wrTl;
    logic wrGl;
    logic wrCwp;
    logic privLevel;
  } strobe_t;

  // process-state field positions
  localparam int PS_PRIV = 2;
  localparam int PS_PEF  = 4;
  localparam logic [15:0] PS_KEEP  = 16'h0BDE;
  localparam logic [15:0] PS_RESET = 16'h0014;

  // hypervisor-state field positions
  localparam int HP_TLZ   = 0;
  localparam int HP_HPRIV = 2;
  localparam int HP_RED   = 5;
  localparam int HP_ID    = 11;
  localparam logic [63:0] HP_RESET = 64'h0000_0000_0000_0824;

endpackage

// File: rtl/lvl_clamp.sv
module lvl_clamp #(
  parameter int W  = 3,
  parameter int HI = 6,
  parameter int LO = 2
) (
  input  logic [63:0]  wrData,
  input  logic         useLow,
  output logic [W-1:0] result
);
  localparam logic [63:0] HI64 = 64'(HI);
  localparam logic [63:0] LO64 = 64'(LO);

  logic [63:0] limit;

  generate
    if (HI == LO) begin : g_fixed
      assign limit = HI64;
    end else begin : g_select
      assign limit = useLow ? LO64 : HI64;
    end
  endgenerate

  assign result = (wrData > limit) ? limit[W-1:0] : wrData[W-1:0];
endmodule

// File: rtl/priv_state_ctrl.sv
module priv_state_ctrl
  import priv_state_pkg::*;
(
  input  logic       wrEn,
  input  logic [2:0] wrSel,
  input  logic       psPriv,
  input  logic       hpPriv,
  output strobe_t    stb
);
  always_comb begin
    stb = '0;
    stb.privLevel = psPriv && !hpPriv;
    if (wrEn) begin
      case (wrSel)
        SEL_PROC: stb.wrPs  = 1'b1;
        SEL_HYP:  stb.wrHp  = 1'b1;
        SEL_TL:   stb.wrTl  = 1'b1;
        SEL_GL:   stb.wrGl  = 1'b1;
        SEL_WIN:  stb.wrCwp = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/priv_state_dp.sv
module priv_state_dp
  import priv_state_pkg::*;
#(
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2,
  parameter int MAX_GL  = 3,
  parameter int MAX_PGL = 2,
  parameter int N_WIN   = 8,
  localparam int TL_W  = $clog2(MAX_TL + 1),
  localparam int GL_W  = $clog2(MAX_GL + 1),
  localparam int CWP_W = $clog2(N_WIN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [63:0]      wrData,
  output logic [15:0]      psQ,
  output logic [63:0]      hpQ,
  output logic [TL_W-1:0]  tlQ,
  output logic [GL_W-1:0]  glQ,
  output logic [CWP_W-1:0] cwpQ,
  output logic             irqQ
);
  logic [TL_W-1:0]  tlClamped;
  logic [GL_W-1:0]  glClamped;
  logic [CWP_W-1:0] cwpClamped;
  logic [TL_W-1:0]  tlNext;
  logic [63:0]      hpNext;
  logic             irqNext;

  lvl_clamp #(.W(TL_W), .HI(MAX_TL), .LO(MAX_PTL)) u_tlClamp (
    .wrData(wrData), .useLow(stb.privLevel), .result(tlClamped));
  lvl_clamp #(.W(GL_W), .HI(MAX_GL), .LO(MAX_PGL)) u_glClamp (
    .wrData(wrData), .useLow(stb.privLevel), .result(glClamped));
  lvl_clamp #(.W(CWP_W), .HI(N_WIN - 1), .LO(N_WIN - 1)) u_cwpClamp (
    .wrData(wrData), .useLow(1'b0), .result(cwpClamped));

  always_comb begin
    tlNext = stb.wrTl ? tlClamped : tlQ;
    hpNext = hpQ;
    if (stb.wrHp) begin
      hpNext = wrData;
      hpNext[HP_ID] = 1'b1;
    end
    irqNext = hpNext[HP_TLZ] && (tlNext == '0) && !hpNext[HP_HPRIV];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psQ  <= PS_RESET;
      hpQ  <= HP_RESET;
      tlQ  <= '0;
      glQ  <= GL_W'(MAX_GL);
      cwpQ <= '0;
      irqQ <= 1'b0;
    end else begin
      if (stb.wrPs)  psQ  <= wrData[15:0] & PS_KEEP;
      if (stb.wrGl)  glQ  <= glClamped;
      if (stb.wrCwp) cwpQ <= cwpClamped;
      tlQ <= tlNext;
      hpQ <= hpNext;
      if (stb.wrTl || stb.wrHp) irqQ <= irqNext;
    end
  end

  // R2: dropped process bits never become set
  p_ps_dropped_r2: assert property (@(posedge clk) disable iff (!rstN)
    (psQ & ~PS_KEEP) == 16'h0);
  // R3: identity bit is set after any hypervisor write
  p_hp_id_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrHp |=> hpQ[HP_ID]);
  // R4: request only while its condition holds on the stored state
  p_irq_cond_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> (hpQ[HP_TLZ] && tlQ == '0 && !hpQ[HP_HPRIV]));
  // R4: request held when neither source register is written
  p_irq_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrTl || stb.wrHp) |=> $stable(irqQ));
  // R5: privileged trap-level writes respect the lower cap
  p_tl_priv_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrTl && stb.privLevel) |=> (tlQ <= TL_W'(MAX_PTL)));
  // R5: trap level never exceeds the upper cap
  p_tl_max_r5: assert property (@(posedge clk) disable iff (!rstN)
    tlQ <= TL_W'(MAX_TL));
  // R6: privileged global-level writes respect the lower cap
  p_gl_priv_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrGl && stb.privLevel) |=> (glQ <= GL_W'(MAX_PGL)));
  // R7: window index stays in range
  p_cwp_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    32'(cwpQ) < N_WIN);
  // R9: no strobe, no change
  p_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrPs | stb.wrHp | stb.wrTl | stb.wrGl | stb.wrCwp) == 1'b0
      |=> ($stable(psQ) && $stable(hpQ) && $stable(tlQ) && $stable(glQ) && $stable(cwpQ)));
endmodule

// File: rtl/priv_state_regs.sv
module priv_state_regs
  import priv_state_pkg::*;
#(
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2,
  parameter int MAX_GL  = 3,
  parameter int MAX_PGL = 2,
  parameter int N_WIN   = 8,
  localparam int TL_W  = $clog2(MAX_TL + 1),
  localparam int GL_W  = $clog2(MAX_GL + 1),
  localparam int CWP_W = $clog2(N_WIN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrSel,
  input  logic [63:0]      wrData,
  output logic [15:0]      procState,
  output logic [63:0]      hypState,
  output logic [TL_W-1:0]  trapLevel,
  output logic [GL_W-1:0]  globalLevel,
  output logic [CWP_W-1:0] windowPtr,
  output logic             userMode,
  output logic             tlZeroIrq
);
  strobe_t stb;

  priv_state_ctrl u_ctrl (
    .wrEn(wrEn), .wrSel(wrSel),
    .psPriv(procState[PS_PRIV]), .hpPriv(hypState[HP_HPRIV]),
    .stb(stb));

  priv_state_dp #(
    .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL), .MAX_GL(MAX_GL),
    .MAX_PGL(MAX_PGL), .N_WIN(N_WIN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .psQ(procState), .hpQ(hypState), .tlQ(trapLevel),
    .glQ(globalLevel), .cwpQ(windowPtr), .irqQ(tlZeroIrq));

  assign userMode = !procState[PS_PRIV] && !hypState[HP_HPRIV];

  // R8: user mode excludes both privilege bits
  p_user_r8: assert property (@(posedge clk) disable iff (!rstN)
    userMode |-> (!procState[PS_PRIV] && !hypState[HP_HPRIV]));
endmodule

// File: tb/sim_priv_state_regs.sv
`timescale 1ns/1ps
module sim_priv_state_regs;
  localparam int MTL = 6, MPTL = 2, MGL = 3, MPGL = 2, NW = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSel = 3'd0;
  logic [63:0] wrData = 64'd0;
  logic [15:0] procState;
  logic [63:0] hypState;
  logic [2:0]  trapLevel;
  logic [1:0]  globalLevel;
  logic [2:0]  windowPtr;
  logic        userMode, tlZeroIrq;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  // model state
  logic [15:0] mPs;
  logic [63:0] mHp;
  int unsigned mTl, mGl, mCwp;
  bit mIrq;

  always #10 clk = ~clk;

  priv_state_regs u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .procState(procState), .hypState(hypState), .trapLevel(trapLevel),
    .globalLevel(globalLevel), .windowPtr(windowPtr),
    .userMode(userMode), .tlZeroIrq(tlZeroIrq));

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int unsigned capVal(input logic [63:0] d, input int unsigned lim);
    return (d > 64'(lim)) ? lim : int'(d[31:0]);
  endfunction

  // expected-state update from the requirements
  function automatic void modelWrite(input bit en, input logic [2:0] sel,
                                     input logic [63:0] d);
    bit privLvl = mPs[2] && !mHp[2];
    if (!en) return;                                   // R9
    case (sel)
      3'd0: mPs = d[15:0] & 16'h0BDE;                  // R2
      3'd1: mHp = d | 64'h800;                         // R3
      3'd2: mTl = capVal(d, privLvl ? MPTL : MTL);     // R5
      3'd3: mGl = capVal(d, privLvl ? MPGL : MGL);     // R6
      3'd4: mCwp = capVal(d, NW - 1);                  // R7
      default: ;                                       // R9
    endcase
    if (sel == 3'd1 || sel == 3'd2)
      mIrq = mHp[0] && mTl == 0 && !mHp[2];            // R4
  endfunction

  task automatic checkAll(input string req);
    chk(procState == mPs, {req, " R2 procState"}, 64'(procState), 64'(mPs));
    chk(hypState == mHp, {req, " R3 hypState"}, hypState, mHp);
    chk(32'(trapLevel) == mTl, {req, " R5 trapLevel"}, 64'(trapLevel), 64'(mTl));
    chk(32'(globalLevel) == mGl, {req, " R6 globalLevel"}, 64'(globalLevel), 64'(mGl));
    chk(32'(windowPtr) == mCwp, {req, " R7 windowPtr"}, 64'(windowPtr), 64'(mCwp));
    chk(userMode == (!mPs[2] && !mHp[2]), {req, " R8 userMode"},
        64'(userMode), 64'(!mPs[2] && !mHp[2]));
    chk(tlZeroIrq == mIrq, {req, " R4 tlZeroIrq"}, 64'(tlZeroIrq), 64'(mIrq));
  endtask

  // drive on falling edge, compare on the next falling edge (R10)
  task automatic doWrite(input bit en, input logic [2:0] sel,
                         input logic [63:0] d, input string req);
    @(negedge clk);
    wrEn = en; wrSel = sel; wrData = d;
    modelWrite(en, sel, d);
    @(negedge clk);
    wrEn = 1'b0;
    checkAll(req);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mPs = 16'h0014; mHp = 64'h824; mTl = 0; mGl = MGL; mCwp = 0; mIrq = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 reset");

    // directed
    doWrite(1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R2 all-ones");
    doWrite(1, 3'd1, 64'h0, "R3 zero write");
    doWrite(1, 3'd0, 64'h0, "R8 user");
    doWrite(1, 3'd1, 64'h1, "R4 tlz raise");
    chk(tlZeroIrq == 1'b1, "R4 raised", 64'(tlZeroIrq), 64'd1);
    doWrite(1, 3'd2, 64'd1, "R4 tl nonzero");
    chk(tlZeroIrq == 1'b0, "R4 dropped", 64'(tlZeroIrq), 64'd0);
    doWrite(1, 3'd2, 64'd0, "R4 tl zero");
    doWrite(1, 3'd2, 64'd100, "R5 user cap");
    chk(trapLevel == 3'(MTL), "R5 user cap value", 64'(trapLevel), 64'(MTL));
    doWrite(0, 3'd2, 64'd1, "R9 enable low");
    doWrite(1, 3'd5, 64'hFFFF, "R9 sel5");
    doWrite(1, 3'd7, 64'hFFFF, "R9 sel7");
    doWrite(1, 3'd0, 64'h4, "R5 set priv");
    doWrite(1, 3'd2, 64'd100, "R5 priv cap");
    chk(trapLevel == 3'(MPTL), "R5 priv cap value", 64'(trapLevel), 64'(MPTL));
    doWrite(1, 3'd3, 64'd100, "R6 priv cap");
    doWrite(1, 3'd1, 64'h4, "R6 set hpriv");
    doWrite(1, 3'd3, 64'd100, "R6 hpriv cap");
    chk(globalLevel == 2'(MGL), "R6 hpriv cap value", 64'(globalLevel), 64'(MGL));
    doWrite(1, 3'd4, 64'd8, "R7 at limit");
    doWrite(1, 3'd4, 64'd5, "R7 in range");
    doWrite(1, 3'd4, 64'hFFFF_0000_0000_0003, "R7 huge");

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [2:0] s = 3'($urandom_range(0, 7));
      logic [63:0] d;
      bit en = ($urandom_range(0, 9) != 0);
      if (s >= 3'd2 && s <= 3'd4 && $urandom_range(0, 3) != 0)
        d = 64'($urandom_range(0, 10));
      else if (s == 3'd1 && $urandom_range(0, 1) == 1)
        d = 64'($urandom_range(0, 7));
      else
        d = {$urandom, $urandom};
      doWrite(en, s, d, "R10 random");
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule